// File: doc/BRIEF.md
# Legacy Port Trap SMI Controller

This block sits beside a USB host controller. It lets system-management firmware take over the legacy keyboard controller ports. It watches the I/O bus for accesses to the keyboard data port (0x0060) and the command/status port (0x0064). It also watches the host controller's interrupt line and a one-cycle "pass-through finished" pulse. Each of these five causes has a status flag that latches when the cause occurs, whatever its enable says. Each cause also has an enable. The SMI output is raised whenever at least one cause has both its status and its enable set.

A single 16-bit control/status word is read and written through a plain register port. The read data is combinational and the write takes effect at the clock edge. The register port and the I/O-observation strobe have no back-pressure: both are accepted in every cycle, so no ready signal exists. The same word holds a gate bit that passes or blocks the host controller's ordinary interrupt towards the system.

Top module: `legacy_trap_smi`

## Requirements
- R1: After reset the register reads 0x2000, `smi_out` is 0, and `usb_irq_out` equals `usb_irq_in`.
- R2: An `io_strobe` with `io_addr` exactly 0x0064 and `io_write`=1 sets bit 11. The same address with `io_write`=0 sets bit 10. Exactly 0x0060 with `io_write`=1 sets bit 9. Each bit reads 1 in the cycle after the strobe edge. No other address, and no read of 0x0060, sets any status bit.
- R3: A `passthru_end` pulse sets bit 15, which reads 1 after that edge.
- R4: A status bit latches even when its enable is 0.
- R5: Writing 1 to bit 15, 11, 10 or 9 (with `reg_be[1]`=1) clears that bit. Writing 0 leaves it unchanged.
- R6: Bit 12 shows `usb_irq_in` as registered one cycle earlier. Register writes have no effect on it.
- R7: Bits 4..0 (enables for the causes at bits 12, 11, 10, 9 and 15, in that order from bit 4 down to bit 0) and bit 13 are read/write. `reg_be[0]` guards bits 7..0 and `reg_be[1]` guards bits 15..8.
- R8: `usb_irq_out` follows `usb_irq_in` while bit 13 is 1 and is 0 while bit 13 is 0.
- R9: `smi_out` is 1 exactly while some status bit and its enable are both 1. It stays 1 until the status bit is cleared or the enable is removed.
- R10: If a cause occurs in the same cycle as a write-1-to-clear of its bit, the bit stays set.
- R11: Bit 14 and bits 8..5 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_strobe | input | 1 | One-cycle marker of an observed I/O access |
| io_addr | input | 16 | I/O address of the observed access |
| io_write | input | 1 | 1 = observed access is a write |
| usb_irq_in | input | 1 | Interrupt request from the USB host controller |
| passthru_end | input | 1 | One-cycle pulse: a pass-through sequence completed |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables of the register write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Current register contents |
| smi_out | output | 1 | System-management interrupt request |
| usb_irq_out | output | 1 | Gated host controller interrupt |

## Verification
The trap decoder is driven with each of the three trapped access kinds and with near misses: a read of the data port, neighbouring addresses, and a match only in the low byte. This separates exact decoding from partial decoding and from ignoring the direction. Status and enable patterns are crossed so that latching without an enable can be told apart from raising the SMI. Writes carrying 0s, writes carrying 1s, and a clear that collides with an event show the clear policy and its priority. The USB interrupt is toggled with the gate bit on and off to show that the mirror ignores writes and that the gate works on its own.

// File: rtl/ltrap_pkg.sv
package ltrap_pkg;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 16;
  localparam int NCAUSE   = 5;  // 0 passthru, 1 wr60, 2 rd64, 3 wr64, 4 usb
  localparam int NSTICKY  = 4;  // causes 0..3 are write-1-to-clear
  localparam int IRQEN_POS = 13;
  localparam int STAT_POS [NCAUSE] = '{15, 9, 10, 11, 12};
  localparam logic [ADDR_W-1:0] PORT_DATA = 16'h0060;
  localparam logic [ADDR_W-1:0] PORT_CMD  = 16'h0064;
  localparam logic [REG_W-1:0]  RESET_VAL = 16'h2000;
endpackage

// File: rtl/ltrap_decode.sv
module ltrap_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              ev_wr_data,
  output logic              ev_rd_cmd,
  output logic              ev_wr_cmd
);
  logic hit_data, hit_cmd;
  assign hit_data   = strobe && (addr == DATA_PORT);
  assign hit_cmd    = strobe && (addr == CMD_PORT);
  assign ev_wr_data = hit_data && wr;
  assign ev_rd_cmd  = hit_cmd && !wr;
  assign ev_wr_cmd  = hit_cmd && wr;
endmodule

// File: rtl/ltrap_sticky.sv
module ltrap_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;   // event beats clear
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ltrap_ctrl.sv
module ltrap_ctrl #(
  parameter int NEN   = 5,
  parameter int REG_W = 16,
  parameter int GATE_POS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  output logic [NEN-1:0]   en_q,
  output logic             gate_q
);
  localparam int GATE_BYTE = GATE_POS / 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      gate_q <= 1'b1;
    end else if (wr) begin
      if (be[0])         en_q   <= wdata[NEN-1:0];
      if (be[GATE_BYTE]) gate_q <= wdata[GATE_POS];
    end
  end
endmodule

// File: rtl/legacy_trap_smi.sv
module legacy_trap_smi
  import ltrap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_strobe,
  input  logic [15:0] io_addr,
  input  logic        io_write,
  input  logic        usb_irq_in,
  input  logic        passthru_end,
  input  logic        reg_wr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        smi_out,
  output logic        usb_irq_out
);
  logic ev_wr60, ev_rd64, ev_wr64;
  logic [NSTICKY-1:0] st_set, st_clr, st_q;
  logic [NCAUSE-1:0]  stat, en;
  logic gate, usb_q;

  ltrap_decode #(.ADDR_W(ADDR_W), .DATA_PORT(PORT_DATA), .CMD_PORT(PORT_CMD)) u_dec (
    .strobe(io_strobe), .addr(io_addr), .wr(io_write),
    .ev_wr_data(ev_wr60), .ev_rd_cmd(ev_rd64), .ev_wr_cmd(ev_wr64)
  );

  assign st_set = {ev_wr64, ev_rd64, ev_wr60, passthru_end};

  for (genvar i = 0; i < NSTICKY; i++) begin : g_clr
    localparam int P = STAT_POS[i];
    assign st_clr[i] = reg_wr && reg_be[P/8] && reg_wdata[P];
  end

  ltrap_sticky #(.N(NSTICKY)) u_st (
    .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(st_clr), .q(st_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) usb_q <= 1'b0;
    else        usb_q <= usb_irq_in;
  end

  ltrap_ctrl #(.NEN(NCAUSE), .REG_W(REG_W), .GATE_POS(IRQEN_POS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .be(reg_be), .wdata(reg_wdata),
    .en_q(en), .gate_q(gate)
  );

  assign stat = {usb_q, st_q};

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCAUSE; i++) begin
      reg_rdata[STAT_POS[i]] = stat[i];
      reg_rdata[i]           = en[i];
    end
    reg_rdata[IRQEN_POS] = gate;
  end

  assign smi_out     = |(stat & en);
  assign usb_irq_out = usb_irq_in && gate;
endmodule

// File: rtl/ltrap_checker.sv
module ltrap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_strobe,
  input logic [15:0] io_addr,
  input logic        io_write,
  input logic        usb_irq_in,
  input logic        passthru_end,
  input logic [15:0] reg_rdata,
  input logic        smi_out,
  input logic        usb_irq_out
);
  a_r2_wr60_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_write && io_addr == 16'h0060) |=> reg_rdata[9]);
  a_r2_rd64_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && !io_write && io_addr == 16'h0064) |=> reg_rdata[10]);
  a_r3_passthru_sets: assert property (@(posedge clk) disable iff (!rst_n)
    passthru_end |=> reg_rdata[15]);
  a_r6_usb_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    usb_irq_in |=> reg_rdata[12]);
  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[13] |-> !usb_irq_out);
  a_r9_smi_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[9] && reg_rdata[1]) |-> smi_out);
  a_r9_no_smi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[4:0] == 5'b0) |-> !smi_out);
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[14] == 1'b0) && (reg_rdata[8:5] == 4'b0));
endmodule

bind legacy_trap_smi ltrap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_addr(io_addr),
  .io_write(io_write), .usb_irq_in(usb_irq_in), .passthru_end(passthru_end),
  .reg_rdata(reg_rdata), .smi_out(smi_out), .usb_irq_out(usb_irq_out)
);

// File: tb/sim_legacy_trap_smi.sv
`timescale 1ns/1ps
module sim_legacy_trap_smi;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_strobe = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_write = 1'b0;
  logic        usb_irq_in = 1'b0;
  logic        passthru_end = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        smi_out, usb_irq_out;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  legacy_trap_smi u0 (
    .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_addr(io_addr),
    .io_write(io_write), .usb_irq_in(usb_irq_in), .passthru_end(passthru_end),
    .reg_wr(reg_wr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .smi_out(smi_out), .usb_irq_out(usb_irq_out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wreg(logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic io(logic [15:0] a, logic w);
    @(negedge clk);
    io_strobe = 1'b1; io_addr = a; io_write = w;
    step();
    io_strobe = 1'b0; io_addr = '0; io_write = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 16'h2000);
    chk("R1 smi", {15'b0, smi_out}, 16'h0);
    chk("R1 irq", {15'b0, usb_irq_out}, 16'h0);
  endtask

  task automatic t_enables();
    wreg(2'b01, 16'hFFFF);
    chk("R7 low byte", reg_rdata, 16'h201F);
    wreg(2'b10, 16'h0000);
    chk("R7 gate off", reg_rdata, 16'h001F);
    wreg(2'b10, 16'hFFFF);
    chk("R11 reserved", reg_rdata, 16'h201F);
    wreg(2'b11, 16'h2000);
    chk("R7 restore", reg_rdata, 16'h2000);
  endtask

  task automatic t_traps();
    io(16'h0060, 1'b1);
    chk("R2 wr60", reg_rdata, 16'h2200);
    chk("R4 no smi", {15'b0, smi_out}, 16'h0);
    io(16'h0064, 1'b0);
    chk("R2 rd64", reg_rdata, 16'h2600);
    io(16'h0064, 1'b1);
    chk("R2 wr64", reg_rdata, 16'h2E00);
    wreg(2'b10, 16'h2E00);
    chk("R5 clear", reg_rdata, 16'h2000);
    io(16'h0060, 1'b0);
    io(16'h0061, 1'b1);
    io(16'h1064, 1'b1);
    io(16'h0065, 1'b0);
    chk("R2 near miss", reg_rdata, 16'h2000);
  endtask

  task automatic t_passthru();
    @(negedge clk); passthru_end = 1'b1; step(); passthru_end = 1'b0;
    chk("R3 set", reg_rdata, 16'hA000);
    chk("R4 no smi", {15'b0, smi_out}, 16'h0);
    wreg(2'b01, 16'h0001);
    chk("R9 smi on", {15'b0, smi_out}, 16'h1);
    step(); step();
    chk("R9 smi held", {15'b0, smi_out}, 16'h1);
    wreg(2'b10, 16'hA000);
    chk("R5 clr15", reg_rdata, 16'h2001);
    chk("R9 smi off", {15'b0, smi_out}, 16'h0);
    wreg(2'b01, 16'h0000);
  endtask

  task automatic t_w1c_zero();
    io(16'h0060, 1'b1);
    wreg(2'b10, 16'h2000);
    chk("R5 zero keeps", reg_rdata, 16'h2200);
    wreg(2'b01, 16'h0200);
    chk("R7 be gates clear", reg_rdata, 16'h2200);
    wreg(2'b10, 16'h2200);
  endtask

  task automatic t_collide();
    @(negedge clk);
    io_strobe = 1'b1; io_addr = 16'h0060; io_write = 1'b1;
    reg_wr = 1'b1; reg_be = 2'b10; reg_wdata = 16'h2200;
    step();
    io_strobe = 1'b0; io_write = 1'b0; io_addr = '0;
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
    chk("R10 event wins", reg_rdata, 16'h2200);
    wreg(2'b10, 16'h2200);
    chk("R10 later clear", reg_rdata, 16'h2000);
  endtask

  task automatic t_usb();
    @(negedge clk); usb_irq_in = 1'b1;
    #1 chk("R8 pass", {15'b0, usb_irq_out}, 16'h1);
    step();
    chk("R6 mirror", reg_rdata, 16'h3000);
    wreg(2'b10, 16'h3000);
    chk("R6 write ignored", reg_rdata, 16'h3000);
    wreg(2'b01, 16'h0010);
    chk("R9 usb smi", {15'b0, smi_out}, 16'h1);
    wreg(2'b10, 16'h1000);
    chk("R7 gate cleared", reg_rdata, 16'h1010);
    chk("R8 blocked", {15'b0, usb_irq_out}, 16'h0);
    @(negedge clk); usb_irq_in = 1'b0;
    step();
    chk("R6 follows low", reg_rdata, 16'h0010);
    chk("R9 smi drops", {15'b0, smi_out}, 16'h0);
    wreg(2'b11, 16'h2000);
  endtask

  task automatic t_disable();
    wreg(2'b01, 16'h0008);
    io(16'h0064, 1'b1);
    chk("R9 wr64 smi", {15'b0, smi_out}, 16'h1);
    wreg(2'b01, 16'h0000);
    chk("R9 disabled", {15'b0, smi_out}, 16'h0);
    chk("R4 status kept", reg_rdata, 16'h2800);
    wreg(2'b10, 16'h2800);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    step(); step();
    @(negedge clk); rst_n = 1'b1;
    step();
    t_reset();
    t_enables();
    t_traps();
    t_passthru();
    t_w1c_zero();
    t_collide();
    t_usb();
    t_disable();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule